// File: doc/BRIEF.md
# Aging-Triggered Pipeline Capture Mode Controller

This controller gathers timing-margin evidence from sensors placed at the inputs of pipeline registers. Each sensor raises a flag in a cycle when an early-sampled copy of its data disagrees with the value the real register captured. Such a flag warns that the path is close to failing. It does not mean that an error has already happened. A single flag sample is not reliable under process variation, so the controller bases its verdict on a window of many samples.

The controller accumulates samples over a programmable window. When enough samples in that window carry a flag, it latches a decision that the logic has aged. It then drives a mode line that moves the inner pipeline stages from conventional capture to time-borrowing capture. The first and last stages always stay conventional. The switch is one-way: only a reset or an explicit clear brings the pipeline back to conventional capture.

Per-sensor saturating hit counters and the progress of the current window are exposed as status. Aging builds up over months, so a long window and a decision latency of a few cycles are acceptable.

Top module: `aging_mode_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tb_mode_o` is 0, `stage_sel_o` is all zero, and all status counters are zero.
- R2: A cycle counts as a sample only when `flag_valid_i` is 1. A sample is a hit when any bit of `flag_i` is 1. When `flag_valid_i` is 0, the flags change no counter and no status.
- R3: A window closes on its N-th sample, where N is `win_len_i` and a value of 0 counts as 1. If the hits in the window, including the closing sample, are greater than or equal to `thresh_i`, `tb_mode_o` is 1 from the cycle after the closing sample. Otherwise the mode is unchanged. In both cases the next window starts empty.
- R4: `tb_mode_o` rises only in the cycle after a window closes. Reaching the threshold early in a window has no effect until that window closes.
- R5: Once `tb_mode_o` is 1, it stays 1 until reset or `clear_i`.
- R6: A cycle with `clear_i` at 1 makes the mode, the stage selects, the per-sensor counters and the window progress all zero in the next cycle. A sample in that same cycle is discarded.
- R7: Bit 0 and bit NUM_STAGES-1 of `stage_sel_o` are always 0. Every other bit equals the value `tb_mode_o` had one cycle earlier. After a clear, all bits are 0.
- R8: Sensor i's counter sits at `sensor_hits_o[8*i +: 8]`. It increases by one for each sample in which flag bit i is 1, and it holds at 255.
- R9: `samples_o` gives the number of samples taken so far in the open window, and `win_hits_o` gives the number of hits among them. Both are 0 right after a window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | NUM_SENSORS | Per-sensor timing-margin flags |
| flag_valid_i | input | 1 | Flags hold a sample this cycle |
| win_len_i | input | WIN_W | Samples per window (0 counts as 1) |
| thresh_i | input | WIN_W | Hits per window needed to declare aging |
| clear_i | input | 1 | Clears the decision, counters and window |
| tb_mode_o | output | 1 | 0 conventional capture, 1 time-borrowing capture |
| stage_sel_o | output | NUM_STAGES | Per-stage capture select; end stages held at 0 |
| sensor_hits_o | output | NUM_SENSORS*8 | Per-sensor saturating hit counters |
| win_hits_o | output | WIN_W | Hits in the open window |
| samples_o | output | WIN_W | Samples taken in the open window |

## Verification
The following outputs reflect a sample or a clear one cycle after the edge that takes it: the counters, the window status and `tb_mode_o`. The stage selects follow one cycle later still, because they are a registered copy of the mode. The bench drives inputs on the falling edge and updates its model at that moment. On the next falling edge it compares every output with the model, so each result is checked in the first cycle it is due, and any extra delay or early change shows up as a mismatch.

// File: rtl/aging_pkg.sv
package aging_pkg;

    localparam int unsigned CNT_W = 8;

    typedef enum logic {
        MODE_CONV   = 1'b0,
        MODE_BORROW = 1'b1
    } cap_mode_e;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/aging_flag_tally.sv
module aging_flag_tally
    import aging_pkg::*;
#(
    parameter int unsigned NUM_SENSORS = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         clr_i,
    input  logic                         valid_i,
    input  logic [NUM_SENSORS-1:0]       flags_i,
    output logic                         hit_o,
    output logic [NUM_SENSORS*CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [NUM_SENSORS-1:0][CNT_W-1:0] cnt;
    } tally_t;

    tally_t st_d, st_q;

    assign hit_o = valid_i & (|flags_i);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (valid_i) begin
            for (int i = 0; i < NUM_SENSORS; i++) begin
                if (flags_i[i]) begin
                    st_d.cnt[i] = sat_inc(st_q.cnt[i]);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_out
        assign cnt_o[g*CNT_W +: CNT_W] = st_q.cnt[g];
    end

endmodule

// File: rtl/aging_window_judge.sv
module aging_window_judge #(
    parameter int unsigned WIN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             valid_i,
    input  logic             hit_i,
    input  logic [WIN_W-1:0] len_i,
    input  logic [WIN_W-1:0] thr_i,
    output logic             trip_o,
    output logic [WIN_W-1:0] samp_o,
    output logic [WIN_W-1:0] hits_o
);

    localparam int unsigned EXT_W = WIN_W + 1;

    typedef struct packed {
        logic [WIN_W-1:0] samp;
        logic [WIN_W-1:0] hits;
    } win_t;

    win_t st_d, st_q;

    logic [EXT_W-1:0] n_eff;
    logic [EXT_W-1:0] total;
    logic [EXT_W-1:0] taken;
    logic             closing;

    always_comb begin
        n_eff   = (len_i == '0) ? EXT_W'(1) : {1'b0, len_i};
        total   = {1'b0, st_q.hits} + EXT_W'(hit_i);
        taken   = {1'b0, st_q.samp} + EXT_W'(1);
        closing = valid_i && !clr_i && (taken >= n_eff);
        trip_o  = closing && (total >= {1'b0, thr_i});

        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (valid_i) begin
            if (closing) begin
                st_d = '0;
            end else begin
                st_d.samp = taken[WIN_W-1:0];
                st_d.hits = total[WIN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_o = st_q.samp;
    assign hits_o = st_q.hits;

endmodule

// File: rtl/aging_mode_hold.sv
module aging_mode_hold
    import aging_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic                  trip_i,
    output logic                  mode_o,
    output logic [NUM_STAGES-1:0] sel_o
);

    typedef struct packed {
        cap_mode_e mode;
        logic      sel;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sel = (st_q.mode == MODE_BORROW);
        if (trip_i) begin
            st_d.mode = MODE_BORROW;
        end
        if (clr_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = (st_q.mode == MODE_BORROW);

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        if (s == 0 || s == NUM_STAGES - 1) begin : g_edge
            assign sel_o[s] = 1'b0;
        end else begin : g_mid
            assign sel_o[s] = st_q.sel;
        end
    end

endmodule

// File: rtl/aging_mode_ctrl.sv
module aging_mode_ctrl
    import aging_pkg::*;
#(
    parameter int unsigned NUM_SENSORS = 4,
    parameter int unsigned NUM_STAGES  = 6,
    parameter int unsigned WIN_W       = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_SENSORS-1:0]       flag_i,
    input  logic                         flag_valid_i,
    input  logic [WIN_W-1:0]             win_len_i,
    input  logic [WIN_W-1:0]             thresh_i,
    input  logic                         clear_i,
    output logic                         tb_mode_o,
    output logic [NUM_STAGES-1:0]        stage_sel_o,
    output logic [NUM_SENSORS*CNT_W-1:0] sensor_hits_o,
    output logic [WIN_W-1:0]             win_hits_o,
    output logic [WIN_W-1:0]             samples_o
);

    logic hit;
    logic trip;

    aging_flag_tally #(
        .NUM_SENSORS(NUM_SENSORS)
    ) u_tally (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clear_i),
        .valid_i(flag_valid_i),
        .flags_i(flag_i),
        .hit_o  (hit),
        .cnt_o  (sensor_hits_o)
    );

    aging_window_judge #(
        .WIN_W(WIN_W)
    ) u_judge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clear_i),
        .valid_i(flag_valid_i),
        .hit_i  (hit),
        .len_i  (win_len_i),
        .thr_i  (thresh_i),
        .trip_o (trip),
        .samp_o (samples_o),
        .hits_o (win_hits_o)
    );

    aging_mode_hold #(
        .NUM_STAGES(NUM_STAGES)
    ) u_hold (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (clear_i),
        .trip_i(trip),
        .mode_o(tb_mode_o),
        .sel_o (stage_sel_o)
    );

endmodule

// File: rtl/aging_mode_ctrl_chk.sv
module aging_mode_ctrl_chk #(
    parameter int unsigned NUM_SENSORS = 4,
    parameter int unsigned NUM_STAGES  = 6,
    parameter int unsigned WIN_W       = 8
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [NUM_SENSORS-1:0]   flag_i,
    input logic                     flag_valid_i,
    input logic [WIN_W-1:0]         win_len_i,
    input logic [WIN_W-1:0]         thresh_i,
    input logic                     clear_i,
    input logic                     tb_mode_o,
    input logic [NUM_STAGES-1:0]    stage_sel_o,
    input logic [NUM_SENSORS*8-1:0] sensor_hits_o,
    input logic [WIN_W-1:0]         win_hits_o,
    input logic [WIN_W-1:0]         samples_o
);

    a_r5_mode_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tb_mode_o && !clear_i |=> tb_mode_o);

    a_r6_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> !tb_mode_o && samples_o == '0 && win_hits_o == '0
                    && sensor_hits_o == '0 && stage_sel_o == '0);

    a_r4_rise_on_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tb_mode_o) |-> samples_o == '0 && win_hits_o == '0);

    a_r7_end_stages: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stage_sel_o[0] && !stage_sel_o[NUM_STAGES-1]);

    a_r7_middle_lags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> stage_sel_o[1] == $past(tb_mode_o));

    a_r9_hits_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_hits_o <= samples_o);

    a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_valid_i && !clear_i |=> $stable(samples_o) && $stable(win_hits_o)
                                      && $stable(sensor_hits_o));

    for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_sat
        a_r8_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !clear_i |=> sensor_hits_o[g*8 +: 8] >= $past(sensor_hits_o[g*8 +: 8]));
    end

endmodule

bind aging_mode_ctrl aging_mode_ctrl_chk #(
    .NUM_SENSORS(NUM_SENSORS),
    .NUM_STAGES (NUM_STAGES),
    .WIN_W      (WIN_W)
) u_chk (.*);

// File: tb/aging_mode_ctrl_tb.sv
module aging_mode_ctrl_tb;

    localparam int NS  = 4;
    localparam int NST = 6;
    localparam int WW  = 8;

    logic            clk = 1'b0;
    logic            rst_ni = 1'b0;
    logic [NS-1:0]   flag_i = '0;
    logic            flag_valid_i = 1'b0;
    logic [WW-1:0]   win_len_i = '0;
    logic [WW-1:0]   thresh_i = '0;
    logic            clear_i = 1'b0;
    logic            tb_mode_o;
    logic [NST-1:0]  stage_sel_o;
    logic [NS*8-1:0] sensor_hits_o;
    logic [WW-1:0]   win_hits_o;
    logic [WW-1:0]   samples_o;

    always #4 clk = ~clk;

    aging_mode_ctrl #(.NUM_SENSORS(NS), .NUM_STAGES(NST), .WIN_W(WW)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .flag_i(flag_i), .flag_valid_i(flag_valid_i),
        .win_len_i(win_len_i), .thresh_i(thresh_i), .clear_i(clear_i),
        .tb_mode_o(tb_mode_o), .stage_sel_o(stage_sel_o), .sensor_hits_o(sensor_hits_o),
        .win_hits_o(win_hits_o), .samples_o(samples_o)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R1";
    int    cfg_len = 1;
    int    cfg_thr = 1;
    int    m_mode = 0;
    int    m_sel = 0;
    int    m_ws = 0;
    int    m_wh = 0;
    int    m_cnt[NS];

    task automatic chk(string t, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    function automatic logic [NST-1:0] exp_sel(int s);
        logic [NST-1:0] v = '0;
        for (int k = 1; k < NST - 1; k++) v[k] = (s != 0);
        return v;
    endfunction

    task automatic compare();
        chk(tag, "mode", tb_mode_o, m_mode);
        chk("R7", "stage_sel", stage_sel_o, exp_sel(m_sel));
        for (int i = 0; i < NS; i++) chk("R8", "sensor_hits", sensor_hits_o[i*8 +: 8], m_cnt[i]);
        chk("R9", "win_hits", win_hits_o, m_wh);
        chk("R9", "samples", samples_o, m_ws);
    endtask

    task automatic model(bit v, logic [NS-1:0] f, bit c);
        int n;
        int tot;
        if (c) begin
            m_mode = 0; m_sel = 0; m_ws = 0; m_wh = 0;
            for (int i = 0; i < NS; i++) m_cnt[i] = 0;
            return;
        end
        m_sel = m_mode;
        if (!v) return;
        for (int i = 0; i < NS; i++) if (f[i] && m_cnt[i] < 255) m_cnt[i]++;
        n   = (cfg_len == 0) ? 1 : cfg_len;
        tot = m_wh + ((f != 0) ? 1 : 0);
        if (m_ws + 1 >= n) begin
            if (tot >= cfg_thr) m_mode = 1;
            m_ws = 0; m_wh = 0;
        end else begin
            m_ws++; m_wh = tot;
        end
    endtask

    task automatic step(bit v, logic [NS-1:0] f, bit c);
        @(negedge clk);
        compare();
        flag_valid_i = v; flag_i = f; clear_i = c;
        win_len_i = WW'(cfg_len); thresh_i = WW'(cfg_thr);
        model(v, f, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < NS; i++) m_cnt[i] = 0;
        // R1: reset state while reset is held
        repeat (3) @(negedge clk);
        chk("R1", "mode in reset", tb_mode_o, 0);
        chk("R1", "sel in reset", stage_sel_o, 0);
        chk("R1", "hits in reset", sensor_hits_o, 0);
        rst_ni = 1'b1;

        // R2: flags with valid low are ignored; clean samples are no hits
        tag = "R2"; cfg_len = 4; cfg_thr = 1;
        step(0, 4'b1111, 0);
        for (int k = 0; k < 4; k++) begin
            step(1, 4'b0000, 0);
            step(0, 4'b1010, 0);
        end
        step(0, 4'b1111, 0);
        chk("R2", "mode after ignored flags", tb_mode_o, 0);

        // R4: threshold reached early; rise only at window close
        tag = "R4"; cfg_len = 8; cfg_thr = 2;
        for (int k = 0; k < 3; k++) step(1, 4'b0100, 0);
        for (int k = 0; k < 5; k++) step(0, 4'b1111, 0);
        for (int k = 0; k < 5; k++) step(1, 4'b0000, 0);
        step(0, 4'b0000, 0);
        chk("R4", "mode after close", tb_mode_o, 1);

        // R5: sticky through further windows that would not trip
        tag = "R5"; cfg_len = 3; cfg_thr = 200;
        for (int k = 0; k < 40; k++) step($urandom % 2, NS'($urandom), 0);

        // R6: clear with a simultaneous hit sample
        tag = "R6";
        step(1, 4'b1111, 1);
        step(0, 4'b0000, 0);
        chk("R6", "mode after clear", tb_mode_o, 0);

        // R3: one hit short, then exactly at threshold on the closing sample
        tag = "R3"; cfg_len = 8; cfg_thr = 3;
        for (int k = 0; k < 8; k++) step(1, (k == 2 || k == 5) ? 4'b0001 : 4'b0000, 0);
        for (int k = 0; k < 8; k++) step(1, (k == 1 || k == 4 || k == 7) ? 4'b1000 : 4'b0000, 0);
        step(0, 4'b0000, 0);
        chk("R3", "mode at exact threshold", tb_mode_o, 1);
        step(0, 4'b0000, 1);

        // R8: saturation of one counter; window length 0 acts as 1
        tag = "R8"; cfg_len = 0; cfg_thr = 2;
        for (int k = 0; k < 300; k++) step(1, 4'b0001, 0);
        step(0, 4'b0000, 0);
        chk("R8", "saturated counter", sensor_hits_o[7:0], 255);
        tag = "R3"; cfg_thr = 1;
        step(1, 4'b0010, 0);
        step(0, 4'b0000, 0);
        chk("R3", "len zero trip", tb_mode_o, 1);
        step(0, 4'b0000, 1);

        // random mix
        for (int c = 0; c < 20; c++) begin
            cfg_len = $urandom % 41;
            cfg_thr = (cfg_len == 0) ? 1 : ($urandom % (cfg_len + 1));
            for (int k = 0; k < 150; k++) begin
                logic [NS-1:0] f;
                for (int b = 0; b < NS; b++) f[b] = ($urandom % 8 == 0);
                step($urandom % 2, f, ($urandom % 200) == 0);
            end
        end
        step(0, 4'b0000, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule